// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block takes a low-power DDR memory device from power-on to a usable state. After a start pulse it raises clock enable. It then switches on the PHY delay-locked loop, starts the loop, and waits for the lock flag. If the loop is to run switched off, the sequencer captures the upper eight bits of the measured lock value as a fixed forced delay and only then clears the loop enable.

Once lock is seen and a minimum interval of stable clock has passed since clock enable rose, the sequencer issues four commands. Each command lasts one cycle, and NOP fills every cycle between them. The order is precharge-all, auto-refresh, auto-refresh and mode-register-set, with a parameterised gap after each command. A done flag then goes high and stays high until reset. Periodic refresh stays blocked until that flag is high.

Top module: `dram_init_seq`

## Requirements
- R1: After reset `cke` is 0. It goes to 1 one cycle after a start pulse is accepted in the idle state, and it stays at 1 until reset.
- R2: `dll_on` rises one cycle after `cke`. `dll_start` rises one cycle after `dll_on`.
- R3: No command other than NOP is issued until `dll_locked` has been seen at 1 after `dll_start` rose.
- R4: With `dll_off_sel`=1, `dll_force` takes `lock_value[9:2]` after lock, and `dll_on` clears one cycle later. `dll_force` then holds that value. With `dll_off_sel`=0, `dll_on` stays at 1 and `dll_force` stays at 0.
- R5: The first command comes at least STABLE_CYC = CLK_MHZ*STABLE_US cycles after `cke` rose.
- R6: `cmd` codes are NOP=0, precharge-all=1, auto-refresh=2 and mode-register-set=3. Exactly four commands are issued, in the order 1,2,2,3. Precharge-all drives `addr` with only bit 10 set. Mode-register-set drives `addr` equal to `mode_data`. Auto-refresh drives `addr` at 0.
- R7: The first refresh comes 1+T_RP cycles after precharge-all. The second refresh comes 1+T_RFC cycles after the first. Mode-register-set comes 1+T_RFC cycles after the second refresh.
- R8: `done` rises 1+T_MRD cycles after mode-register-set and stays at 1 until reset. `ref_allow` is 0 whenever `done` is 0, and 1 once `done` is 1.
- R9: A start pulse has no effect while the sequence runs or after `done`. The command stream, its timing and `done` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| dll_off_sel | input | 1 | Run the DLL switched off with a forced delay |
| dll_locked | input | 1 | DLL lock flag |
| lock_value | input | 10 | Measured lock value |
| mode_data | input | ADDRW | Mode-register operating parameters |
| cmd | output | 3 | Command code |
| addr | output | ADDRW | Command address |
| cke | output | 1 | Clock enable |
| dll_on | output | 1 | DLL enable |
| dll_start | output | 1 | DLL start |
| dll_force | output | 8 | Forced delay value |
| ref_allow | output | 1 | Periodic refresh permitted |
| done | output | 1 | Initialization complete |

## Verification
Lock arrival is varied against the stable-clock interval. Early lock shows whether the stable-clock timer gates the first command. Lock arriving after the timer has run out shows whether the lock flag gates it. Runs with the DLL-off path selected are mixed with runs where it is not, using extreme lock values, so that a wrong bit slice or a wrong capture order gives a wrong forced delay. Start pulses are injected mid-run and after completion to show that the command stream cannot be restarted or shifted.

// File: rtl/dram_init_seq.sv
module dram_init_seq #(
  parameter int CLK_MHZ   = 100,
  parameter int STABLE_US = 200,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 12,
  parameter int T_MRD     = 2,
  parameter int ADDRW     = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dll_off_sel,
  input  logic             dll_locked,
  input  logic [9:0]       lock_value,
  input  logic [ADDRW-1:0] mode_data,
  output logic [2:0]       cmd,
  output logic [ADDRW-1:0] addr,
  output logic             cke,
  output logic             dll_on,
  output logic             dll_start,
  output logic [7:0]       dll_force,
  output logic             ref_allow,
  output logic             done
);
  localparam int STABLE_CYC = CLK_MHZ * STABLE_US;
  localparam int CW   = $clog2(STABLE_CYC + 1);
  localparam int TMAX = (T_RP > T_RFC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                       : ((T_RFC > T_MRD) ? T_RFC : T_MRD);
  localparam int GW   = $clog2(TMAX + 1) + 1;
  localparam logic [2:0] C_NOP = 3'd0, C_PALL = 3'd1, C_REF = 3'd2, C_MRS = 3'd3;
  localparam logic [ADDRW-1:0] A_ALLBANK = ADDRW'(1) << 10;

  typedef enum logic [3:0] {
    S_IDLE, S_CKE, S_DLLON, S_GO, S_LOCK, S_FORCE, S_OFF, S_STABLE,
    S_PALL, S_GRP, S_REF1, S_GRF1, S_REF2, S_GRF2, S_MRS, S_GMRD
  } st_t;

  st_t           st;
  logic [CW-1:0] stab_q;
  logic [GW-1:0] gap_q;
  logic          lock_seen_q;
  logic          fin_q;
  logic          gap_end;

  assign gap_end = (gap_q <= GW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      stab_q <= '0;
      gap_q <= '0;
      lock_seen_q <= 1'b0;
      fin_q <= 1'b0;
      cke <= 1'b0;
      dll_on <= 1'b0;
      dll_start <= 1'b0;
      dll_force <= '0;
    end else begin
      if (cke && stab_q != CW'(STABLE_CYC)) stab_q <= stab_q + CW'(1);
      if (!gap_end) gap_q <= gap_q - GW'(1);
      case (st)
        S_IDLE:   if (start && !fin_q) begin cke <= 1'b1; st <= S_CKE; end
        S_CKE:    begin dll_on <= 1'b1; st <= S_DLLON; end
        S_DLLON:  begin dll_start <= 1'b1; st <= S_GO; end
        S_GO:     st <= S_LOCK;
        S_LOCK:   if (dll_locked) begin
                    lock_seen_q <= 1'b1;
                    st <= dll_off_sel ? S_FORCE : S_STABLE;
                  end
        S_FORCE:  begin dll_force <= lock_value[9:2]; st <= S_OFF; end
        S_OFF:    begin dll_on <= 1'b0; st <= S_STABLE; end
        S_STABLE: if (stab_q == CW'(STABLE_CYC)) st <= S_PALL;
        S_PALL:   begin gap_q <= GW'(T_RP);  st <= S_GRP; end
        S_GRP:    if (gap_end) st <= S_REF1;
        S_REF1:   begin gap_q <= GW'(T_RFC); st <= S_GRF1; end
        S_GRF1:   if (gap_end) st <= S_REF2;
        S_REF2:   begin gap_q <= GW'(T_RFC); st <= S_GRF2; end
        S_GRF2:   if (gap_end) st <= S_MRS;
        S_MRS:    begin gap_q <= GW'(T_MRD); st <= S_GMRD; end
        S_GMRD:   if (gap_end) begin fin_q <= 1'b1; st <= S_IDLE; end
        default:  st <= S_IDLE;
      endcase
    end
  end

  assign cmd = (st == S_PALL) ? C_PALL :
               (st == S_REF1 || st == S_REF2) ? C_REF :
               (st == S_MRS) ? C_MRS : C_NOP;
  assign addr = (st == S_MRS) ? mode_data : (st == S_PALL) ? A_ALLBANK : '0;
  assign done = fin_q;
  assign ref_allow = fin_q && cke;

  AST_CKE_HELD: assert property (@(posedge clk) disable iff (!rst_n) cke |=> cke); // R1
  AST_START_AFTER_ON: assert property (@(posedge clk) disable iff (!rst_n) $rose(dll_start) |-> dll_on); // R2
  AST_CMD_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (cmd != C_NOP) |-> lock_seen_q); // R3
  AST_CMD_AFTER_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (cmd != C_NOP) |-> (stab_q == CW'(STABLE_CYC))); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done |=> done); // R8
  AST_NO_CMD_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (cmd == C_NOP)); // R9
endmodule

// File: tb/sim_dram_init_seq.sv
module sim_dram_init_seq;
  localparam int MHZ = 1, SUS = 200, TRP = 3, TRFC = 7, TMRD = 2, AW = 13;
  localparam int STAB = MHZ * SUS;

  logic clk = 0, rst_n = 0, start = 0, dll_off_sel = 0, dll_locked = 0;
  logic [9:0] lock_value = 0;
  logic [AW-1:0] mode_data = 0;
  logic [2:0] cmd;
  logic [AW-1:0] addr;
  logic cke, dll_on, dll_start, ref_allow, done;
  logic [7:0] dll_force;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dram_init_seq #(.CLK_MHZ(MHZ), .STABLE_US(SUS), .T_RP(TRP), .T_RFC(TRFC),
                  .T_MRD(TMRD), .ADDRW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dll_off_sel(dll_off_sel),
    .dll_locked(dll_locked), .lock_value(lock_value), .mode_data(mode_data),
    .cmd(cmd), .addr(addr), .cke(cke), .dll_on(dll_on), .dll_start(dll_start),
    .dll_force(dll_force), .ref_allow(ref_allow), .done(done));

  function automatic logic [7:0] exp_force(logic [9:0] lv);
    return lv[9:2];
  endfunction
  function automatic logic [2:0] exp_code(int k);
    return (k == 0) ? 3'd1 : (k == 3) ? 3'd3 : 3'd2;
  endfunction
  function automatic int exp_gap(int k);
    return (k == 0) ? 1 + TRP : (k == 3) ? 1 + TMRD : 1 + TRFC;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; start = 0; dll_locked = 0;
    repeat (3) @(negedge clk);
    chk(cke == 0 && cmd == 0 && dll_on == 0 && dll_start == 0 && done == 0 && ref_allow == 0 && dll_force == 0,
        "R1", "reset state", {cke, dll_on, dll_start, done, ref_allow}, 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run_case(int lockd, bit off, logic [9:0] lv, logic [AW-1:0] md, int xs);
    int cke_c = -1, on_c = -1, st_c = -1, fall_c = -1, done_c = -1;
    int cyc_of[4];
    int ncmd = 0, post = 0;
    bit bad_order = 0, bad_addr = 0, cke_drop = 0, ref_early = 0, done_drop = 0;
    logic [7:0] force_at_fall = 0;
    logic pcke = 0, pon = 0, pst = 0, pdone = 0;
    do_reset();
    dll_off_sel = off; lock_value = lv; mode_data = md;
    start = 1;
    for (int cyc = 1; cyc < 3000; cyc++) begin
      @(negedge clk);
      if (cke && !pcke) cke_c = cyc;
      if (!cke && pcke) cke_drop = 1;
      if (dll_on && !pon && on_c < 0) on_c = cyc;
      if (!dll_on && pon && fall_c < 0) begin fall_c = cyc; force_at_fall = dll_force; end
      if (dll_start && !pst) st_c = cyc;
      if (ref_allow != done) ref_early = 1;
      if (!done && pdone) done_drop = 1;
      if (done && !pdone) done_c = cyc;
      if (cmd != 0) begin
        if (ncmd < 4) begin
          cyc_of[ncmd] = cyc;
          if (cmd != exp_code(ncmd)) bad_order = 1;
          if (ncmd == 0 && addr != (AW'(1) << 10)) bad_addr = 1;
          if (ncmd == 3 && addr != md) bad_addr = 1;
          if ((ncmd == 1 || ncmd == 2) && addr != 0) bad_addr = 1;
        end
        ncmd++;
      end
      pcke = cke; pon = dll_on; pst = dll_start; pdone = done;
      if (done_c >= 0) post++;
      start = (cyc + 1 == xs) || (post == 3);
      dll_locked = (cyc + 1 >= lockd);
      if (post >= 20) break;
    end
    chk(cke_c == 1, "R1", "cke rise cycle", cke_c, 1);
    chk(!cke_drop, "R1", "cke held", cke_drop, 0);
    chk(on_c == cke_c + 1 && st_c == on_c + 1, "R2", "dll_on/dll_start order", st_c - on_c, 1);
    chk(ncmd == 4 && !bad_order, "R6", "command count/order", ncmd, 4);
    chk(!bad_addr, "R6", "command address", bad_addr, 0);
    if (ncmd >= 1) begin
      chk(cyc_of[0] > lockd, "R3", "first cmd after lock", cyc_of[0], lockd + 1);
      chk(cyc_of[0] - cke_c >= STAB, "R5", "stable interval", cyc_of[0] - cke_c, STAB);
    end
    for (int k = 0; k < 3; k++)
      if (ncmd > k + 1)
        chk(cyc_of[k + 1] - cyc_of[k] == exp_gap(k), "R7", "command gap", cyc_of[k + 1] - cyc_of[k], exp_gap(k));
    if (ncmd >= 4)
      chk(done_c - cyc_of[3] == exp_gap(3), "R8", "done delay", done_c - cyc_of[3], exp_gap(3));
    chk(!done_drop && done == 1, "R8", "done sticky", done, 1);
    chk(!ref_early, "R8", "ref_allow tracks done", ref_early, 0);
    if (xs > 0 || 1) chk(ncmd == 4, "R9", "start ignored", ncmd, 4);
    if (off) begin
      chk(fall_c > 0 && force_at_fall == exp_force(lv), "R4", "force captured before dll off", force_at_fall, exp_force(lv));
      chk(dll_force == exp_force(lv) && dll_on == 0, "R4", "force held, dll off", dll_force, exp_force(lv));
    end else begin
      chk(dll_on == 1 && dll_force == 0 && fall_c < 0, "R4", "dll stays on", {dll_on, dll_force}, 9'h100);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    run_case(4, 0, 10'h155, 13'h0032, 0);
    run_case(400, 1, 10'h3FF, 13'h1FFF, 0);
    run_case(50, 1, 10'h003, 13'h0000, 0);
    run_case(STAB + 1, 0, 10'h200, 13'h0A5A, 30);
    run_case(10, 1, 10'h2AA, 13'h1234, 205);
    for (int i = 0; i < 12; i++) begin
      int ld = $urandom_range(4, STAB + 60);
      bit of = 1'($urandom_range(0, 1));
      logic [9:0] lv = 10'($urandom);
      logic [AW-1:0] md = AW'($urandom);
      int xs = ($urandom_range(0, 1) == 1) ? $urandom_range(2, STAB + 20) : 0;
      run_case(ld, of, lv, md, xs);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule